// File: doc/BRIEF.md
# Memory Controller Operating-State Sequencer

This block holds the operating state of a dynamic memory controller and the timing and geometry settings that the rest of the controller reads. Software reaches it over a simple 32-bit register bus. A write to the command register asks for a state change. The block only makes that change when the request is legal in the current state. A read of the status register returns the present state. Software brings the controller up in a fixed order: it writes the timing and geometry registers in the configure state, issues a go command, and then polls status until ready is reported.

Entry into and exit from low power use a four-phase handshake with the memory side. A sleep command raises the low-power request. The block reports the low-power state only after the memory side acknowledges. A wakeup command drops the request, and the block reports ready again only after the acknowledge has fallen. Configuration registers are writable only in the configure state. A write at any other time is discarded.

Top module: `memctl_state_ctrl`

## Requirements
- R1: After synchronous reset the block is in the configure state: status bits [1:0] read 0, `ready_o` is low and `lp_req_o` is low.
- R2: The status register at byte offset 0x00 reports the state in bits [1:0] (0 configure, 1 ready, 2 paused, 3 low power), with all other bits zero. A write to offset 0x04 is a command whose code is taken from bits [2:0]: 0 go, 1 sleep, 2 wakeup, 3 pause, 4 configure, 7 active pause.
- R3: Go moves configure to ready and paused to ready. `ready_o` is high exactly when the block is settled in the ready state.
- R4: Pause (3) and active pause (7) move ready to paused.
- R5: Sleep from ready raises `lp_req_o` on the next cycle and drops `ready_o`. Status keeps reading 1 until `mem_ack_i` is seen high, and then reads 3.
- R6: Wakeup from low power drops `lp_req_o` on the next cycle. Status keeps reading 3 until `mem_ack_i` is seen low, and then reads 1 with `ready_o` high.
- R7: Configure (4) moves ready or paused back to the configure state.
- R8: Codes 5 and 6, and any code not legal in the current state, leave the state unchanged. This includes every command given while a low-power handshake is in progress.
- R9: The geometry register at 0x0C keeps only column code [2:0], row code [5:3], burst code [17:15] and active-chips-minus-one [22:21]. All other bits read 0.
- R10: The eighteen timing registers at 0x10 through 0x54, spaced 4 bytes apart, read back the full 32-bit value written in the configure state.
- R11: Writes to 0x0C through 0x54 outside the configure state are ignored, and every register keeps its old value.
- R12: Configuration registers reset to 0. Reads of the command offset, of unmapped offsets and of misaligned offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | ADDR_W (8) | Byte offset for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ready_o | output | 1 | High while the controller is in the ready state |
| lp_req_o | output | 1 | Low-power request to the memory side |
| mem_ack_i | input | 1 | Low-power acknowledge from the memory side |

## Verification
The bench targets the illegal-command cases. It gives sleep from configure, wakeup from ready, go during low power, and the reserved codes 5 and 6. A design that treats any of these as legal shows a status change on the very next read. It also writes configuration data in the ready, paused and low-power states. A design that does not gate these writes returns the new data when the register is read back. The bench holds the acknowledge at the wrong level for several cycles. This exposes a design that reports low power or ready before the handshake is done. The bench also writes all-ones to the geometry register, which exposes a wrong field mask.

// File: rtl/memctl_pkg.sv
package memctl_pkg;

    localparam int DATA_W      = 32;
    localparam int OFS_STATUS  = 'h00;
    localparam int OFS_CMD     = 'h04;
    localparam int OFS_GEOM    = 'h0C;
    localparam int OFS_LAST    = 'h54;
    localparam int N_CFG       = (OFS_LAST - OFS_GEOM) / 4 + 1;
    localparam int CFG_IDX_W   = $clog2(N_CFG);
    localparam logic [DATA_W-1:0] GEOM_KEEP = 32'h0063_803F;

    typedef enum logic [2:0] {
        MS_CFG, MS_READY, MS_PAUSED, MS_LOWPWR, MS_ENTER_LP, MS_LEAVE_LP
    } mstate_e;

    typedef enum logic [2:0] {
        CMD_GO     = 3'd0,
        CMD_SLEEP  = 3'd1,
        CMD_WAKE   = 3'd2,
        CMD_PAUSE  = 3'd3,
        CMD_CONFIG = 3'd4,
        CMD_RSV5   = 3'd5,
        CMD_RSV6   = 3'd6,
        CMD_APAUSE = 3'd7
    } cmd_e;

    function automatic logic [1:0] status_code(mstate_e s);
        case (s)
            MS_CFG:      return 2'd0;
            MS_READY:    return 2'd1;
            MS_ENTER_LP: return 2'd1;
            MS_PAUSED:   return 2'd2;
            default:     return 2'd3;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] keep_mask(int idx);
        return (idx == 0) ? GEOM_KEEP : '1;
    endfunction

    function automatic mstate_e next_state(mstate_e cur, logic vld, cmd_e c, logic ack);
        mstate_e nx;
        nx = cur;
        case (cur)
            MS_CFG:
                if (vld && c == CMD_GO) nx = MS_READY;
            MS_READY:
                if (vld) begin
                    case (c)
                        CMD_SLEEP:             nx = MS_ENTER_LP;
                        CMD_PAUSE, CMD_APAUSE: nx = MS_PAUSED;
                        CMD_CONFIG:            nx = MS_CFG;
                        default:               nx = cur;
                    endcase
                end
            MS_PAUSED:
                if (vld && c == CMD_GO)          nx = MS_READY;
                else if (vld && c == CMD_CONFIG) nx = MS_CFG;
            MS_LOWPWR:
                if (vld && c == CMD_WAKE) nx = MS_LEAVE_LP;
            MS_ENTER_LP:
                if (ack) nx = MS_LOWPWR;
            MS_LEAVE_LP:
                if (!ack) nx = MS_READY;
            default:
                nx = MS_CFG;
        endcase
        return nx;
    endfunction

endpackage

// File: rtl/memctl_op_fsm.sv
module memctl_op_fsm
    import memctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_vld,
    input  cmd_e       cmd,
    input  logic       mem_ack,
    output logic [1:0] state_code,
    output logic       ready,
    output logic       lp_req,
    output logic       cfg_open
);
    mstate_e state_q;

    always_ff @(posedge clk) begin
        if (rst) state_q <= MS_CFG;
        else     state_q <= next_state(state_q, cmd_vld, cmd, mem_ack);
    end

    always_comb begin
        state_code = status_code(state_q);
        ready      = (state_q == MS_READY);
        lp_req     = (state_q == MS_ENTER_LP) || (state_q == MS_LOWPWR);
        cfg_open   = (state_q == MS_CFG);
    end
endmodule

// File: rtl/memctl_cfg_bank.sv
module memctl_cfg_bank
    import memctl_pkg::*;
#(
    parameter int N     = N_CFG,
    parameter int IDX_W = $clog2(N)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic [DATA_W-1:0]   rd_data,
    output logic [N*DATA_W-1:0] flat
);
    logic [DATA_W-1:0] bank [N];

    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (rst)
                bank[i] <= '0;
            else if (wr_en && wr_idx == IDX_W'(i))
                bank[i] <= wdata & keep_mask(i);
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < N; i++)
            if (rd_idx == IDX_W'(i)) rd_data = bank[i];
    end

    for (genvar g = 0; g < N; g++) begin : g_flat
        assign flat[g*DATA_W +: DATA_W] = bank[g];
    end
endmodule

// File: rtl/memctl_state_ctrl.sv
module memctl_state_ctrl
    import memctl_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              ready_o,
    output logic              lp_req_o,
    input  logic              mem_ack_i
);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_CMD    = ADDR_W'(OFS_CMD);
    localparam logic [ADDR_W-1:0] A_FIRST  = ADDR_W'(OFS_GEOM);
    localparam logic [ADDR_W-1:0] A_LAST   = ADDR_W'(OFS_LAST);

    logic                      cmd_vld;
    logic [2:0]                cmd_code;
    logic [1:0]                state_code;
    logic                      cfg_open;
    logic                      cfg_hit;
    logic [ADDR_W-1:0]         cfg_off;
    logic [CFG_IDX_W-1:0]      cfg_idx;
    logic [DATA_W-1:0]         cfg_rd;
    logic [N_CFG*DATA_W-1:0]   cfg_flat;

    assign cmd_vld  = bus_wr && (bus_addr == A_CMD);
    assign cmd_code = bus_wdata[2:0];
    assign cfg_hit  = (bus_addr >= A_FIRST) && (bus_addr <= A_LAST) && (bus_addr[1:0] == 2'b00);
    assign cfg_off  = bus_addr - A_FIRST;
    assign cfg_idx  = cfg_off[CFG_IDX_W+1:2];

    memctl_op_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .cmd_vld    (cmd_vld),
        .cmd        (cmd_e'(cmd_code)),
        .mem_ack    (mem_ack_i),
        .state_code (state_code),
        .ready      (ready_o),
        .lp_req     (lp_req_o),
        .cfg_open   (cfg_open)
    );

    memctl_cfg_bank #(.N(N_CFG), .IDX_W(CFG_IDX_W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (bus_wr && cfg_hit && cfg_open),
        .wr_idx  (cfg_idx),
        .wdata   (bus_wdata),
        .rd_idx  (cfg_idx),
        .rd_data (cfg_rd),
        .flat    (cfg_flat)
    );

    always_comb begin
        if (bus_addr == A_STATUS) bus_rdata = {30'd0, state_code};
        else if (cfg_hit)         bus_rdata = cfg_rd;
        else                      bus_rdata = '0;
    end
endmodule

// File: rtl/memctl_state_ctrl_chk.sv
module memctl_state_ctrl_chk
    import memctl_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    bus_wr,
    input logic                    cmd_vld,
    input logic [2:0]              cmd_code,
    input logic [1:0]              state_code,
    input logic                    ready_o,
    input logic                    lp_req_o,
    input logic                    mem_ack_i,
    input logic                    cfg_open,
    input logic [N_CFG*DATA_W-1:0] cfg_flat
);
    assert_reset_cfg_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (state_code == 2'd0 && !ready_o && !lp_req_o));

    assert_ready_code_R3: assert property (@(posedge clk) disable iff (rst)
        ready_o |-> state_code == 2'd1);

    assert_go_cfg_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd_vld && cmd_code == 3'd0 && state_code == 2'd0) |=> (ready_o && state_code == 2'd1));

    assert_pause_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd_vld && (cmd_code == 3'd3 || cmd_code == 3'd7) && ready_o) |=> state_code == 2'd2);

    assert_lpreq_rise_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(lp_req_o) |-> $past(ready_o));

    assert_enter_wait_R5: assert property (@(posedge clk) disable iff (rst)
        (lp_req_o && !mem_ack_i && state_code == 2'd1) |=> state_code == 2'd1);

    assert_lpreq_fall_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(lp_req_o) |-> state_code == 2'd3);

    assert_reserved_R8: assert property (@(posedge clk) disable iff (rst)
        (cmd_vld && (cmd_code == 3'd5 || cmd_code == 3'd6) &&
         (ready_o || state_code == 2'd0 || state_code == 2'd2)) |=> $stable(state_code));

    assert_locked_R11: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !cfg_open) |=> $stable(cfg_flat));
endmodule

bind memctl_state_ctrl memctl_state_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/memctl_state_ctrl_bench.sv
module memctl_state_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ready_o, lp_req_o;
    logic        mem_ack_i = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    int m_st = 0;
    logic [31:0] m_reg [19];
    logic [31:0] m_wr_data;
    int m_wr_idx;

    always #2.5 clk = ~clk;

    memctl_state_ctrl u_memctl_state_ctrl (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ready_o(ready_o),
        .lp_req_o(lp_req_o), .mem_ack_i(mem_ack_i)
    );

    function automatic bit is_cfg(logic [7:0] a);
        return a >= 8'h0C && a <= 8'h54 && a[1:0] == 2'b00;
    endfunction

    function automatic int nxt(int s, bit vld, int c, bit ack);
        case (s)
            0: return (vld && c == 0) ? 1 : 0;
            1: if (!vld) return 1;
               else if (c == 1) return 4;
               else if (c == 3 || c == 7) return 2;
               else if (c == 4) return 0;
               else return 1;
            2: if (vld && c == 0) return 1;
               else if (vld && c == 4) return 0;
               else return 2;
            3: return (vld && c == 2) ? 5 : 3;
            4: return ack ? 3 : 4;
            default: return ack ? 5 : 1;
        endcase
    endfunction

    function automatic int code_of(int s);
        return (s == 4) ? 1 : (s == 5) ? 3 : s;
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(bit w, logic [7:0] a, logic [31:0] d);
        bit vld;
        bus_wr = w; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        vld = w && a == 8'h04;
        if (w && is_cfg(a) && m_st == 0) begin
            m_wr_idx = (a - 8'h0C) >> 2;
            m_wr_data = (m_wr_idx == 0) ? (d & 32'h0063_803F) : d;
            m_reg[m_wr_idx] = m_wr_data;
        end
        m_st = nxt(m_st, vld, int'(d[2:0]), mem_ack_i);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic check_state(string req);
        bus_addr = 8'h00;
        #1;
        chk(bus_rdata == 32'(code_of(m_st)), req, bus_rdata, 32'(code_of(m_st)));
        chk(ready_o == (m_st == 1), req, 32'(ready_o), 32'(m_st == 1));
        chk(lp_req_o == (m_st == 3 || m_st == 4), req, 32'(lp_req_o), 32'(m_st == 3 || m_st == 4));
    endtask

    task automatic check_reg(logic [7:0] a, string req);
        logic [31:0] e;
        bus_addr = a;
        #1;
        e = is_cfg(a) ? m_reg[(a - 8'h0C) >> 2] : (a == 8'h00 ? 32'(code_of(m_st)) : 32'd0);
        chk(bus_rdata == e, req, bus_rdata, e);
    endtask

    task automatic cmd(int c, string req);
        step(1'b1, 8'h04, 32'(c));
        check_state(req);
    endtask

    initial begin
        #500000;
        n_fail++; n_chk++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 19; i++) m_reg[i] = '0;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_state("R1 reset state");
        for (int i = 0; i < 19; i++) check_reg(8'(12 + 4 * i), "R12 reset value");
        check_reg(8'h04, "R12 command reads zero");
        check_reg(8'h08, "R12 unmapped");
        check_reg(8'h58, "R12 unmapped high");
        check_reg(8'h11, "R12 misaligned");

        // R9 geometry mask and R10 timing read-back
        step(1'b1, 8'h0C, 32'hFFFF_FFFF);
        check_reg(8'h0C, "R9 geometry mask");
        for (int i = 1; i < 19; i++) begin
            step(1'b1, 8'(12 + 4 * i), 32'hA500_0000 + 32'(i * 32'h0101_0011));
            check_reg(8'(12 + 4 * i), "R10 timing readback");
        end

        // R8 illegal in configure
        cmd(5, "R8 code5 in cfg");
        cmd(6, "R8 code6 in cfg");
        cmd(1, "R8 sleep in cfg");
        cmd(2, "R8 wake in cfg");
        cmd(3, "R8 pause in cfg");
        cmd(0, "R3 go from cfg");
        step(1'b1, 8'h20, 32'hDEAD_BEEF);
        check_reg(8'h20, "R11 write in ready ignored");
        cmd(2, "R8 wake in ready");
        cmd(3, "R4 pause");
        step(1'b1, 8'h0C, 32'h0);
        check_reg(8'h0C, "R11 write in paused ignored");
        cmd(0, "R3 go from paused");
        cmd(7, "R4 active pause");
        cmd(4, "R7 config from paused");
        cmd(0, "R3 go again");
        cmd(4, "R7 config from ready");
        cmd(0, "R3 go third");

        // R5 sleep handshake
        cmd(1, "R5 sleep requested");
        repeat (3) begin step(1'b0, 8'h00, 0); check_state("R5 waiting for ack"); end
        cmd(0, "R8 go during entry");
        mem_ack_i = 1'b1;
        step(1'b0, 8'h00, 0); check_state("R5 low power reached");
        cmd(0, "R8 go in low power");
        cmd(3, "R8 pause in low power");
        step(1'b1, 8'h30, 32'h1234_5678);
        check_reg(8'h30, "R11 write in low power ignored");
        // R6 wake handshake
        cmd(2, "R6 wakeup requested");
        repeat (3) begin step(1'b0, 8'h00, 0); check_state("R6 waiting for ack drop"); end
        mem_ack_i = 1'b0;
        step(1'b0, 8'h00, 0); check_state("R6 ready again");

        // mixed random stimulus
        for (int n = 0; n < 600; n++) begin
            int r;
            r = int'($urandom % 8);
            if (r < 4) step(1'b1, 8'h04, 32'($urandom % 8));
            else if (r < 6) step(1'b1, 8'(12 + 4 * ($urandom % 19)), $urandom);
            else if (r == 6) begin mem_ack_i = ~mem_ack_i; step(1'b0, 8'h00, 0); end
            else step(1'b0, 8'h00, 0);
            check_state("R2 R8 random state");
            check_reg(8'(12 + 4 * ($urandom % 19)), "R10 R11 random register");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule